// File: doc/BRIEF.md
# Boot-locked operating mode controller

This block holds the operating-mode settings of the system and lets them be changed only while the boot program is still mapped. It has two small registers on a simple CPU bus. The mode-select register carries a legacy-compatibility bit and a request bit for an external-LCD-control mode. The object-priority register chooses how the video unit orders overlapping objects. A third address is the boot-unmap register. Any nonzero write to it hides the boot program and freezes the mode-select register until the next reset.

The boot sequence can set the registers with ordinary bus writes. It can also pulse `cart_apply` with the cartridge compatibility byte. The block then applies the same decode that boot firmware would apply.

Priority writes made during boot are held in a staged copy. They reach the video unit when the lock is taken. While the external-LCD request is set and no STOP has arrived yet, a priority write reaches the output at once, even after the lock. The external-LCD output itself rises only when a STOP pulse arrives while the request bit is set.

Top module: `bootmode_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `legacy_mode`, `obj_x_priority` and `ext_lcd_mode` are 0, `boot_rom_mapped` is 1 and `bus_rdata` is 0xFF.
- R2: While unlocked, a bus write to 0xFF4C stores data bits 3 and 2. `legacy_mode` shows stored bit 2 from the cycle after the write.
- R3: A write of any nonzero value to 0xFF50 sets the lock, and `boot_rom_mapped` is 0 from the next cycle on. A write of zero has no effect.
- R4: Once locked, bus writes to 0xFF4C are dropped until reset. Both `legacy_mode` and the read-back value are unchanged.
- R5: Reads are registered, so `bus_rdata` shows the value for the address seen on the previous edge. 0xFF4C reads 1s except bit 3 (external-LCD request) and bit 2 (legacy). 0xFF6C reads 1s except bit 0 (staged priority). 0xFF50 reads 0xFE while mapped and 0xFF once locked. Any other address reads 0xFF.
- R6: While unlocked, a `cart_apply` pulse with bit 7 of `cart_compat` set copies `cart_compat` bits 3 and 2 into the mode register and leaves priority untouched. Bit 6 has no effect, so 0xC8 and 0x88 give the same result.
- R7: While unlocked, a `cart_apply` pulse with bit 7 clear sets the mode register to the value 0x04 would give (legacy 1, request 0). It also sets the staged priority to 1.
- R8: While locked, `cart_apply` has no effect on any register.
- R9: While unlocked and no external-LCD change is pending, a write to 0xFF6C updates only the staged priority (bit 0). `obj_x_priority` takes the staged value on the cycle after the locking write.
- R10: While mode bit 3 is set and no STOP has been recorded (pending), a write to 0xFF6C drives `obj_x_priority` from the next cycle, whether locked or not.
- R11: While locked and not pending, writes to 0xFF6C are dropped: the read-back and `obj_x_priority` are unchanged.
- R12: `ext_lcd_mode` rises on the cycle after a `stop_pulse` sampled while mode bit 3 is set. A STOP with bit 3 clear does nothing. The output falls two cycles after a write that clears bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Registered read data |
| stop_pulse | input | 1 | One-cycle pulse when the CPU executes STOP |
| cart_apply | input | 1 | One-cycle pulse to apply the compatibility decode |
| cart_compat | input | 8 | Cartridge compatibility byte |
| legacy_mode | output | 1 | CPU runs in monochrome-compatible mode |
| obj_x_priority | output | 1 | Video unit orders objects by X coordinate |
| ext_lcd_mode | output | 1 | External-LCD-control mode active |
| boot_rom_mapped | output | 1 | Boot program still visible |

## Verification
The assertions take for granted that `cart_apply` and a bus write never land in the same cycle. If they did, the decode would silently win over the write. The assertions also assume `stop_pulse` is one cycle wide and reset is held for at least one edge before any traffic. The stimulus drives each input only through tasks that raise one strobe for a single cycle and clear it at the next falling edge. It re-applies reset between scenarios, so every run of locking and STOP ordering starts from the reset state.

// File: rtl/bootmode_pkg.sv
package bootmode_pkg;
  localparam int LEGACY_BIT  = 2;
  localparam int EXTREQ_BIT  = 3;
  localparam int CART_CGB_BIT = 7;

  typedef struct packed {
    logic ext_req;
    logic legacy;
  } mode_t;
endpackage

// File: rtl/bootmode_lock.sv
module bootmode_lock (
  input  logic clk,
  input  logic rst,
  input  logic unmap_wr_i,
  output logic locked_o,
  output logic lock_evt_o
);
  logic locked_q;

  always_ff @(posedge clk) begin
    if (rst) locked_q <= 1'b0;
    else if (unmap_wr_i) locked_q <= 1'b1;
  end

  assign locked_o   = locked_q;
  assign lock_evt_o = unmap_wr_i & ~locked_q;

  // R3: the lock never releases without reset
  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> locked_q);
endmodule

// File: rtl/bootmode_sel.sv
module bootmode_sel
  import bootmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       locked_i,
  input  logic       wr_i,
  input  logic [1:0] wsel_i,
  input  logic       cart_apply_i,
  input  logic       cart_cgb_i,
  input  logic [1:0] cart_sel_i,
  output mode_t      mode_o
);
  mode_t mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (!locked_i) begin
      if (cart_apply_i) begin
        if (cart_cgb_i) mode_q <= mode_t'(cart_sel_i);
        else            mode_q <= '{ext_req: 1'b0, legacy: 1'b1};
      end else if (wr_i) begin
        mode_q <= mode_t'(wsel_i);
      end
    end
  end

  assign mode_o = mode_q;

  // R4: locked mode register is frozen
  p_mode_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    locked_i |=> $stable(mode_q));
endmodule

// File: rtl/bootmode_prio.sv
module bootmode_prio (
  input  logic clk,
  input  logic rst,
  input  logic locked_i,
  input  logic lock_evt_i,
  input  logic pending_i,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic cart_legacy_i,
  output logic stage_o,
  output logic live_o
);
  logic stage_q;
  logic live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= 1'b0;
      live_q  <= 1'b0;
    end else begin
      if (wr_i && pending_i) begin
        stage_q <= wbit_i;
        live_q  <= wbit_i;
      end else if (wr_i && !locked_i) begin
        stage_q <= wbit_i;
      end
      if (cart_legacy_i) stage_q <= 1'b1;
      if (lock_evt_i)    live_q  <= stage_q;
    end
  end

  assign stage_o = stage_q;
  assign live_o  = live_q;

  // R9: staged value reaches the output on the lock edge
  p_live_on_lock_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_i) |-> live_q == $past(stage_q));
  // R11: locked and not pending: output cannot move
  p_drop_after_lock_r11: assert property (@(posedge clk) disable iff (rst)
    (locked_i && !pending_i) |=> $stable(live_q));
endmodule

// File: rtl/bootmode_ext.sv
module bootmode_ext (
  input  logic clk,
  input  logic rst,
  input  logic stop_i,
  input  logic req_i,
  output logic armed_o,
  output logic pending_o
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst)          armed_q <= 1'b0;
    else if (armed_q) armed_q <= req_i;
    else              armed_q <= stop_i & req_i;
  end

  assign armed_o   = armed_q;
  assign pending_o = req_i & ~armed_q;

  // R12: activation only follows a STOP seen with the request bit set
  p_ext_needs_stop_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> ($past(stop_i) && $past(req_i)));
endmodule

// File: rtl/bootmode_ctrl.sv
module bootmode_ctrl
  import bootmode_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR  = 16'hFF4C,
  parameter logic [ADDR_W-1:0] PRIO_ADDR  = 16'hFF6C,
  parameter logic [ADDR_W-1:0] UNMAP_ADDR = 16'hFF50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              stop_pulse,
  input  logic              cart_apply,
  input  logic [DATA_W-1:0] cart_compat,
  output logic              legacy_mode,
  output logic              obj_x_priority,
  output logic              ext_lcd_mode,
  output logic              boot_rom_mapped
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic  wr_mode, wr_prio, wr_unmap;
  logic  locked, lock_evt, pending, armed;
  logic  prio_stage, prio_live;
  logic  cart_legacy;
  mode_t mode;
  logic  [DATA_W-1:0] rd_d, rd_q;
  logic  cart_unused;

  assign wr_mode  = bus_we && (bus_addr == MODE_ADDR);
  assign wr_prio  = bus_we && (bus_addr == PRIO_ADDR);
  assign wr_unmap = bus_we && (bus_addr == UNMAP_ADDR) && (|bus_wdata);
  assign cart_legacy = cart_apply && !cart_compat[CART_CGB_BIT] && !locked;
  assign cart_unused = ^{cart_compat[6:4], cart_compat[1:0]};

  bootmode_lock u_lock (
    .clk(clk), .rst(rst), .unmap_wr_i(wr_unmap),
    .locked_o(locked), .lock_evt_o(lock_evt)
  );

  bootmode_sel u_sel (
    .clk(clk), .rst(rst), .locked_i(locked),
    .wr_i(wr_mode),
    .wsel_i({bus_wdata[EXTREQ_BIT], bus_wdata[LEGACY_BIT]}),
    .cart_apply_i(cart_apply),
    .cart_cgb_i(cart_compat[CART_CGB_BIT]),
    .cart_sel_i({cart_compat[EXTREQ_BIT], cart_compat[LEGACY_BIT]}),
    .mode_o(mode)
  );

  bootmode_ext u_ext (
    .clk(clk), .rst(rst), .stop_i(stop_pulse), .req_i(mode.ext_req),
    .armed_o(armed), .pending_o(pending)
  );

  bootmode_prio u_prio (
    .clk(clk), .rst(rst), .locked_i(locked), .lock_evt_i(lock_evt),
    .pending_i(pending), .wr_i(wr_prio), .wbit_i(bus_wdata[0]),
    .cart_legacy_i(cart_legacy),
    .stage_o(prio_stage), .live_o(prio_live)
  );

  always_comb begin
    rd_d = ALL_ONES;
    if (bus_addr == MODE_ADDR) begin
      rd_d[EXTREQ_BIT] = mode.ext_req;
      rd_d[LEGACY_BIT] = mode.legacy;
    end else if (bus_addr == PRIO_ADDR) begin
      rd_d[0] = prio_stage;
    end else if (bus_addr == UNMAP_ADDR) begin
      rd_d[0] = locked;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= ALL_ONES;
    else     rd_q <= rd_d;
  end

  assign bus_rdata       = rd_q;
  assign legacy_mode     = mode.legacy;
  assign obj_x_priority  = prio_live;
  assign ext_lcd_mode    = armed;
  assign boot_rom_mapped = ~locked;

  // R2: an accepted mode write shows on legacy_mode next cycle
  p_mode_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_mode && !locked && !cart_apply) |=> legacy_mode == $past(bus_wdata[LEGACY_BIT]));
endmodule

// File: tb/tb_bootmode_ctrl.sv
module tb_bootmode_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_wdata = 8'h00;
  logic        bus_we = 1'b0;
  logic        stop_pulse = 1'b0;
  logic        cart_apply = 1'b0;
  logic [7:0]  cart_compat = 8'h00;
  logic [7:0]  bus_rdata;
  logic        legacy_mode, obj_x_priority, ext_lcd_mode, boot_rom_mapped;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  bit m_locked, m_b3, m_b2, m_stage, m_live, m_armed;
  logic [7:0] m_rd;

  always #2 clk = ~clk;

  bootmode_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .stop_pulse(stop_pulse),
    .cart_apply(cart_apply), .cart_compat(cart_compat),
    .legacy_mode(legacy_mode), .obj_x_priority(obj_x_priority),
    .ext_lcd_mode(ext_lcd_mode), .boot_rom_mapped(boot_rom_mapped)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit pend, wm, wp, wu, n_b3, n_b2, n_stage, n_live, n_armed, n_locked;
    if (rst) begin
      m_locked = 0; m_b3 = 0; m_b2 = 0; m_stage = 0; m_live = 0; m_armed = 0;
      m_rd = 8'hFF;
      return;
    end
    pend = m_b3 && !m_armed;
    wm = bus_we && bus_addr == 16'hFF4C;
    wp = bus_we && bus_addr == 16'hFF6C;
    wu = bus_we && bus_addr == 16'hFF50 && bus_wdata != 0;
    case (bus_addr)
      16'hFF4C: m_rd = {4'hF, m_b3, m_b2, 2'b11};
      16'hFF6C: m_rd = {7'h7F, m_stage};
      16'hFF50: m_rd = {7'h7F, m_locked};
      default:  m_rd = 8'hFF;
    endcase
    n_b3 = m_b3; n_b2 = m_b2; n_stage = m_stage; n_live = m_live;
    n_armed = m_armed ? m_b3 : (stop_pulse && m_b3);
    if (!m_locked && cart_apply) begin
      if (cart_compat[7]) begin n_b3 = cart_compat[3]; n_b2 = cart_compat[2]; end
      else begin n_b3 = 0; n_b2 = 1; n_stage = 1; end
    end else if (!m_locked && wm) begin
      n_b3 = bus_wdata[3]; n_b2 = bus_wdata[2];
    end
    if (wp && pend) begin n_stage = bus_wdata[0]; n_live = bus_wdata[0]; end
    else if (wp && !m_locked) n_stage = bus_wdata[0];
    n_locked = m_locked;
    if (wu && !m_locked) begin n_locked = 1; n_live = m_stage; end
    m_b3 = n_b3; m_b2 = n_b2; m_stage = n_stage; m_live = n_live;
    m_armed = n_armed; m_locked = n_locked;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R2 legacy_mode vs model", legacy_mode, m_b2);
    check("R9 obj_x_priority vs model", obj_x_priority, m_live);
    check("R12 ext_lcd_mode vs model", ext_lcd_mode, m_armed);
    check("R3 boot_rom_mapped vs model", boot_rom_mapped, !m_locked);
    check("R5 bus_rdata vs model", bus_rdata, m_rd);
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0; tick();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; tick(); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    bus_addr = a; tick();
  endtask

  task automatic cart(input logic [7:0] c);
    cart_compat = c; cart_apply = 1'b1; tick(); cart_apply = 1'b0;
  endtask

  task automatic stop();
    stop_pulse = 1'b1; tick(); stop_pulse = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1
    check("R1 legacy after reset", legacy_mode, 0);
    check("R1 xprio after reset", obj_x_priority, 0);
    check("R1 ext after reset", ext_lcd_mode, 0);
    check("R1 mapped after reset", boot_rom_mapped, 1);
    check("R1 rdata after reset", bus_rdata, 8'hFF);

    wr(16'hFF4C, 8'h04);
    check("R2 legacy set by write", legacy_mode, 1);
    rd(16'hFF4C);
    check("R5 mode readback", bus_rdata, 8'hF7);
    wr(16'hFF4C, 8'h00);
    check("R2 legacy cleared by write", legacy_mode, 0);

    cart(8'h00);
    check("R7 legacy from decode", legacy_mode, 1);
    rd(16'hFF6C);
    check("R7 staged priority from decode", bus_rdata, 8'hFF);
    check("R9 output still old priority", obj_x_priority, 0);

    cart(8'hC8);
    rd(16'hFF4C);
    check("R6 decode 0xC8 readback", bus_rdata, 8'hFB);
    cart(8'h88);
    rd(16'hFF4C);
    check("R6 decode 0x88 same as 0xC8", bus_rdata, 8'hFB);
    rd(16'hFF6C);
    check("R6 priority untouched", bus_rdata, 8'hFF);

    wr(16'hFF6C, 8'h01);
    check("R10 pending write immediate", obj_x_priority, 1);
    cart(8'h80);
    wr(16'hFF6C, 8'h00);
    check("R9 unlocked write staged only", obj_x_priority, 1);
    rd(16'hFF6C);
    check("R9 staged readback", bus_rdata, 8'hFE);

    stop();
    check("R12 stop with bit3 clear", ext_lcd_mode, 0);

    wr(16'hFF50, 8'h00);
    check("R3 zero unmap write ignored", boot_rom_mapped, 1);
    rd(16'hFF50);
    check("R5 unmap reads FE while mapped", bus_rdata, 8'hFE);
    wr(16'hFF50, 8'h11);
    check("R3 unmapped after nonzero", boot_rom_mapped, 0);
    check("R9 staged priority applied at lock", obj_x_priority, 0);

    wr(16'hFF4C, 8'h0C);
    check("R4 legacy frozen", legacy_mode, 0);
    rd(16'hFF4C);
    check("R4 mode readback frozen", bus_rdata, 8'hF3);
    cart(8'h00);
    check("R8 decode ignored when locked", legacy_mode, 0);
    rd(16'hFF6C);
    check("R8 priority stage untouched", bus_rdata, 8'hFE);
    wr(16'hFF6C, 8'h01);
    check("R11 locked priority write dropped", obj_x_priority, 0);
    rd(16'hFF6C);
    check("R11 locked priority readback", bus_rdata, 8'hFE);
    rd(16'hFF50);
    check("R5 unmap reads FF when locked", bus_rdata, 8'hFF);
    rd(16'h1234);
    check("R5 other address", bus_rdata, 8'hFF);

    // pending external-LCD request across the lock
    do_reset();
    cart(8'h88);
    wr(16'hFF50, 8'h01);
    wr(16'hFF6C, 8'h01);
    check("R10 pending write after lock", obj_x_priority, 1);
    stop();
    check("R12 ext after stop", ext_lcd_mode, 1);
    wr(16'hFF6C, 8'h00);
    check("R11 write dropped once stop seen", obj_x_priority, 1);

    // clearing the request before the lock
    do_reset();
    wr(16'hFF4C, 8'h08);
    check("R12 no ext before stop", ext_lcd_mode, 0);
    stop();
    check("R12 ext rises", ext_lcd_mode, 1);
    wr(16'hFF4C, 8'h00);
    check("R12 ext still high one cycle", ext_lcd_mode, 1);
    tick();
    check("R12 ext falls second cycle", ext_lcd_mode, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule